// File: doc/BRIEF.md
# Asynchronous Parallel Memory Controller

This block connects an internal request port to an external asynchronous parallel memory bus. The bus is 16 bits wide and has three active-low chip selects. Each request carries a word address, and the top bits of that address pick the chip select. The controller then runs one read or one write on the bus. It drives active-low chip-select, output-enable and write-enable strobes, and it times every phase by counting wait-state ticks. One tick is a fixed number of clock cycles.

Every chip select has its own set of four wait counts: one read count, one write setup count, one write strobe count and one write hold count. A slow peripheral can therefore share the bus with the boot memory without slowing it down. Software computes each count as the required time divided by the tick length, rounded up, and writes it through a small configuration port.

Chip select 0 is reserved for the boot memory, which must be present. Chip selects 1 and 2 serve optional memories or peripherals. The requester holds `req_valid` until `req_ready` pulses. For a read, `req_rdata` is valid in that same cycle.

Top module: `apm_ctrl`

## Requirements
- R1: After reset all chip selects, `mem_oe_n` and `mem_we_n` are high, `mem_dq_oe` and `req_ready` are low, and every wait count of every chip select holds 31.
- R2: Request address bits [25:24] give the region. Region k (k = 0..2) drives only `mem_cs_n[k]` low, and bits [23:0] appear on `mem_addr` for the whole access.
- R3: A request with region 3 asserts no strobe. `req_ready` pulses in the cycle after acceptance, and `req_rdata` is 0.
- R4: A read holds chip select and `mem_oe_n` low together for the read count in ticks. During that time `mem_we_n` stays high and `mem_dq_oe` stays low.
- R5: Read data is taken from `mem_dq_in` at the final clock edge of the read phase. It is returned on `req_rdata` while `req_ready` is high.
- R6: A write first holds chip select low with `mem_we_n` high for the setup count in ticks. During this phase `mem_dq_oe` is high and the write data is on `mem_dq_out`.
- R7: A write then holds `mem_we_n` low for the strobe count in ticks, with chip select low and data driven.
- R8: After `mem_we_n` rises, chip select and driven data stay valid for the hold count in ticks.
- R9: A wait count of 0 behaves exactly as a count of 1.
- R10: The configuration port writes one count per cycle. The field codes are 0 for read, 1 for setup, 2 for strobe and 3 for hold, and `cfg_cs` picks which chip select's set is written. A write to one chip select's set leaves the timing of the other chip selects unchanged.
- R11: `req_ready` is high for exactly one cycle per access. In that cycle all strobes are released and `mem_dq_oe` is low. In the next cycle all chip selects are still high.
- R12: One tick lasts TICK_DIV clock cycles, so a phase with count N lasts N×TICK_DIV cycles.
- R13: A configuration write can land on the same clock edge at which the controller loads that count into a phase. In that case the phase uses the previous value, and the new value applies from the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_cs | input | 2 | Chip select whose count set is written |
| cfg_field | input | 2 | Count select: 0 read, 1 setup, 2 strobe, 3 hold |
| cfg_wdata | input | 5 | New wait count |
| req_valid | input | 1 | Request present, held until `req_ready` |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 26 | Region [25:24] and word address [23:0] |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | 16 | Read data, valid with `req_ready` |
| mem_cs_n | output | 3 | Active-low chip selects |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_addr | output | 24 | External word address |
| mem_dq_out | output | 16 | Data driven to the bus |
| mem_dq_oe | output | 1 | High while the controller drives the data bus |
| mem_dq_in | input | 16 | Data read from the bus |

## Verification
A configuration write and a phase load can fall on the same clock edge. This happens when software retunes the strobe count of the chip select that is in the middle of a write.

The bench provokes this case on purpose. It watches the strobes, counts setup cycles against its own model, and raises `cfg_we` exactly in the last setup cycle. It then checks that the strobe phase still lasts the old count, and that the following write to the same chip select uses the new count.

The read capture edge is judged in a similar way. The bench drives valid data on the bus only in the final read cycle, so any capture that is one cycle early or late returns the wrong word.

// File: rtl/apm_pkg.sv
package apm_pkg;
   // Index of a wait count inside one chip select's count set.
   typedef enum logic [1:0] {
      FLD_RD = 2'd0,
      FLD_SU = 2'd1,
      FLD_PW = 2'd2,
      FLD_HD = 2'd3
   } ws_field_e;

   localparam int unsigned NUM_FIELDS = 4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD,
      ST_WSU,
      ST_WPU,
      ST_WHO,
      ST_GAP
   } seq_state_e;
endpackage

// File: rtl/apm_wait_regs.sv
module apm_wait_regs #(
   parameter int CS_N     = 3,
   parameter int SEL_W    = 2,
   parameter int WS_W     = 5,
   parameter int WS_RESET = 31
) (
   input  logic                                            clk,
   input  logic                                            rst_n,
   input  logic                                            cfg_we,
   input  logic [SEL_W-1:0]                                cfg_cs,
   input  logic [1:0]                                      cfg_field,
   input  logic [WS_W-1:0]                                 cfg_wdata,
   output logic [apm_pkg::NUM_FIELDS-1:0][WS_W-1:0]        ws_eff [CS_N]
);
   localparam logic [WS_W-1:0] RST_V = WS_W'(WS_RESET);
   localparam int              NF    = apm_pkg::NUM_FIELDS;

   for (genvar g = 0; g < CS_N; g++) begin : g_cs
      logic [NF-1:0][WS_W-1:0] q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= {NF{RST_V}};
         end else if (cfg_we && cfg_cs == SEL_W'(g)) begin
            q[cfg_field] <= cfg_wdata;
         end
      end

      // A stored zero is promoted to one tick.
      for (genvar f = 0; f < NF; f++) begin : g_fld
         assign ws_eff[g][f] = (q[f] == '0) ? WS_W'(1) : q[f];
      end
   end
endmodule

// File: rtl/apm_region_decode.sv
module apm_region_decode #(
   parameter int CS_N   = 3,
   parameter int SEL_W  = 2,
   parameter int ADDR_W = 24,
   parameter int REQ_AW = 26
) (
   input  logic [REQ_AW-1:0] req_addr,
   output logic [SEL_W-1:0]  sel,
   output logic              hit,
   output logic [ADDR_W-1:0] word
);
   assign sel  = req_addr[REQ_AW-1 -: SEL_W];
   assign word = req_addr[ADDR_W-1:0];

   if ((2 ** SEL_W) == CS_N) begin : g_full
      assign hit = 1'b1;
   end else begin : g_partial
      assign hit = (sel <= SEL_W'(CS_N - 1));
   end
endmodule

// File: rtl/apm_phase_timer.sv
module apm_phase_timer #(
   parameter int WS_W     = 5,
   parameter int TICK_DIV = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [WS_W-1:0] load_val,
   output logic            done
);
   logic            tick;
   logic [WS_W-1:0] cnt;

   if (TICK_DIV == 1) begin : g_direct
      assign tick = 1'b1;
   end else begin : g_prescale
      localparam int PRE_W = $clog2(TICK_DIV);
      logic [PRE_W-1:0] pre;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              pre <= '0;
         else if (load)                           pre <= '0;
         else if (pre == PRE_W'(TICK_DIV - 1))    pre <= '0;
         else                                     pre <= pre + PRE_W'(1);
      end
      assign tick = (pre == PRE_W'(TICK_DIV - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt <= '0;
      else if (load)                cnt <= load_val;
      else if (tick && cnt != '0)   cnt <= cnt - WS_W'(1);
   end

   assign done = tick && (cnt == WS_W'(1));
endmodule

// File: rtl/apm_ctrl.sv
module apm_ctrl #(
   parameter int  CS_N     = 3,
   parameter int  ADDR_W   = 24,
   parameter int  DATA_W   = 16,
   parameter int  WS_W     = 5,
   parameter int  WS_RESET = 31,
   parameter int  TICK_DIV = 1,
   localparam int SEL_W    = (CS_N > 1) ? $clog2(CS_N) : 1,
   localparam int REQ_AW   = ADDR_W + SEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [SEL_W-1:0]  cfg_cs,
   input  logic [1:0]        cfg_field,
   input  logic [WS_W-1:0]   cfg_wdata,
   input  logic              req_valid,
   input  logic              req_we,
   input  logic [REQ_AW-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic [DATA_W-1:0] req_rdata,
   output logic [CS_N-1:0]   mem_cs_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);
   import apm_pkg::*;

   if (CS_N < 1)                                  begin : g_bad_cs   $error("CS_N must be at least 1"); end
   if (WS_RESET < 1 || WS_RESET >= (2 ** WS_W))   begin : g_bad_rst  $error("WS_RESET out of range"); end
   if (TICK_DIV < 1)                              begin : g_bad_div  $error("TICK_DIV must be at least 1"); end

   logic [NUM_FIELDS-1:0][WS_W-1:0] ws_eff [CS_N];
   logic [SEL_W-1:0]  dec_sel;
   logic              dec_hit;
   logic [ADDR_W-1:0] dec_word;

   seq_state_e        state;
   logic [SEL_W-1:0]  cs_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rdata_q;
   logic              ready_q;

   logic              load;
   logic [WS_W-1:0]   load_val;
   logic              done;
   logic              active;

   apm_wait_regs #(.CS_N(CS_N), .SEL_W(SEL_W), .WS_W(WS_W), .WS_RESET(WS_RESET)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_cs(cfg_cs),
      .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .ws_eff(ws_eff)
   );

   apm_region_decode #(.CS_N(CS_N), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .REQ_AW(REQ_AW)) u_dec (
      .req_addr(req_addr), .sel(dec_sel), .hit(dec_hit), .word(dec_word)
   );

   apm_phase_timer #(.WS_W(WS_W), .TICK_DIV(TICK_DIV)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .done(done)
   );

   // Which count enters the timer, and when.
   always_comb begin
      load     = 1'b0;
      load_val = WS_W'(1);
      unique case (state)
         ST_IDLE: begin
            load     = req_valid && dec_hit;
            load_val = req_we ? ws_eff[dec_sel][FLD_SU] : ws_eff[dec_sel][FLD_RD];
         end
         ST_WSU: begin
            load     = done;
            load_val = ws_eff[cs_q][FLD_PW];
         end
         ST_WPU: begin
            load     = done;
            load_val = ws_eff[cs_q][FLD_HD];
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cs_q    <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
         ready_q <= 1'b0;
      end else begin
         ready_q <= 1'b0;
         unique case (state)
            ST_IDLE: if (req_valid) begin
               cs_q    <= dec_sel;
               addr_q  <= dec_word;
               wdata_q <= req_wdata;
               if (!dec_hit) begin
                  rdata_q <= '0;
                  ready_q <= 1'b1;
                  state   <= ST_GAP;
               end else begin
                  state   <= req_we ? ST_WSU : ST_RD;
               end
            end
            ST_RD: if (done) begin
               rdata_q <= mem_dq_in;
               ready_q <= 1'b1;
               state   <= ST_GAP;
            end
            ST_WSU: if (done) state <= ST_WPU;
            ST_WPU: if (done) state <= ST_WHO;
            ST_WHO: if (done) begin
               ready_q <= 1'b1;
               state   <= ST_GAP;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign active = (state == ST_RD) || (state == ST_WSU) || (state == ST_WPU) || (state == ST_WHO);

   for (genvar i = 0; i < CS_N; i++) begin : g_csn
      assign mem_cs_n[i] = !(active && cs_q == SEL_W'(i));
   end

   assign mem_oe_n   = (state != ST_RD);
   assign mem_we_n   = (state != ST_WPU);
   assign mem_dq_oe  = (state == ST_WSU) || (state == ST_WPU) || (state == ST_WHO);
   assign mem_addr   = addr_q;
   assign mem_dq_out = wdata_q;
   assign req_ready  = ready_q;
   assign req_rdata  = rdata_q;
endmodule

// File: rtl/apm_ctrl_chk.sv
module apm_ctrl_chk #(
   parameter int CS_N   = 3,
   parameter int ADDR_W = 24,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic [CS_N-1:0]   mem_cs_n,
   input logic              mem_oe_n,
   input logic              mem_we_n,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_dq_out,
   input logic              mem_dq_oe
);
   a_r2_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~mem_cs_n));

   a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!(&mem_cs_n) && !(&$past(mem_cs_n))) |-> ($stable(mem_addr) && $stable(mem_cs_n)));

   a_r4_oe_in_read: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> (!(&mem_cs_n) && mem_we_n && !mem_dq_oe));

   a_r7_we_in_write: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!(&mem_cs_n) && mem_dq_oe && mem_oe_n));

   a_r8_data_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

   a_r11_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |=> !req_ready);

   a_r11_ready_released: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> ((&mem_cs_n) && mem_oe_n && mem_we_n && !mem_dq_oe));

   a_r11_gap_after: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |=> (&mem_cs_n));
endmodule

bind apm_ctrl apm_ctrl_chk #(.CS_N(CS_N), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_apm_chk (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_cs_n(mem_cs_n),
   .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
   .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
);

// File: tb/apm_ctrl_bench.sv
module apm_ctrl_bench;
   localparam int TD = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_cs = '0;
   logic [1:0]  cfg_field = '0;
   logic [4:0]  cfg_wdata = '0;
   logic        req_valid = 1'b0;
   logic        req_we = 1'b0;
   logic [25:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        req_ready;
   logic [15:0] req_rdata;
   logic [2:0]  mem_cs_n;
   logic        mem_oe_n, mem_we_n, mem_dq_oe;
   logic [23:0] mem_addr;
   logic [15:0] mem_dq_out;
   logic [15:0] mem_dq_in = '0;

   int    checks = 0;
   int    errors = 0;
   bit    finished = 0;
   string ctx = "";
   int    ws [3][4];

   always #4 clk = ~clk;

   apm_ctrl #(.TICK_DIV(TD)) u_apm_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_cs(cfg_cs), .cfg_field(cfg_field),
      .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_ready(req_ready), .req_rdata(req_rdata),
      .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
      .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   task automatic chk(input bit ok, input string rq, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s [%s] actual=%0d expected=%0d", rq, what, ctx, act, exp);
      end
   endtask

   function automatic int eff(input int v);
      return (v == 0) ? 1 : v;
   endfunction

   task automatic cfg(input int cs, input int fld, input int val);
      @(negedge clk);
      cfg_we = 1'b1; cfg_cs = 2'(cs); cfg_field = 2'(fld); cfg_wdata = 5'(val);
      ws[cs][fld] = val;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic access(input bit we, input int region, input logic [23:0] word,
                         input logic [15:0] wd, input bit coll, input int coll_val);
      bit mapped = (region < 3);
      int e_rd = 0, e_su = 0, e_pw = 0, e_hd = 0;
      int rd = 0, su = 0, pw = 0, hd = 0, cyc = 0, badcs = 0, badsig = 0;
      bit got = 0;
      logic [15:0] pat = word[15:0] ^ 16'hA5C3;
      string rq;
      if (mapped) begin
         e_rd = eff(ws[region][0]) * TD;
         e_su = eff(ws[region][1]) * TD;
         e_pw = eff(ws[region][2]) * TD;
         e_hd = eff(ws[region][3]) * TD;
      end
      @(negedge clk);
      req_valid = 1'b1; req_we = we; req_addr = {2'(region), word}; req_wdata = wd;
      mem_dq_in = ~pat;
      while (!got && cyc < 600) begin
         @(negedge clk);
         cyc++;
         cfg_we = 1'b0;
         if (req_ready) begin
            got = 1;
         end else if (!mapped) begin
            if (!(&mem_cs_n)) badcs++;
         end else begin
            if (mem_cs_n != ~(3'b001 << region)) badcs++;
            if (mem_addr != word) badsig++;
            if (we) begin
               if (!mem_dq_oe || mem_dq_out != wd || !mem_oe_n) badsig++;
               if (!mem_we_n) pw++;
               else if (pw == 0) su++;
               else hd++;
               // R13: raise the config write in the last setup cycle
               if (coll && mem_we_n && pw == 0 && su == e_su) begin
                  cfg_we = 1'b1; cfg_cs = 2'(region); cfg_field = 2'd2; cfg_wdata = 5'(coll_val);
                  ws[region][2] = coll_val;
               end
            end else begin
               if (mem_oe_n || !mem_we_n || mem_dq_oe) badsig++;
               rd++;
               mem_dq_in = (rd == e_rd) ? pat : ~pat;
            end
         end
      end
      req_valid = 1'b0;
      chk(got, "R11", "ready seen", got, 1);
      chk(badcs == 0, mapped ? "R2" : "R3", "chip select violations", badcs, 0);
      chk(badsig == 0, we ? "R6" : "R4", "strobe/data violations", badsig, 0);
      if (!mapped) begin
         chk(cyc == 1, "R3", "cycles to ready", cyc, 1);
         chk(req_rdata == 16'h0, "R3", "rdata", req_rdata, 0);
      end else if (we) begin
         rq = (ws[region][1] == 0) ? "R9" : "R6/R12";
         chk(su == e_su, rq, "setup cycles", su, e_su);
         rq = (ws[region][2] == 0) ? "R9" : "R7/R12";
         chk(pw == e_pw, rq, "strobe cycles", pw, e_pw);
         rq = (ws[region][3] == 0) ? "R9" : "R8/R12";
         chk(hd == e_hd, rq, "hold cycles", hd, e_hd);
      end else begin
         rq = (ws[region][0] == 0) ? "R9" : "R4/R12";
         chk(rd == e_rd, rq, "read cycles", rd, e_rd);
         chk(req_rdata == pat, "R5", "rdata", req_rdata, pat);
      end
      chk((&mem_cs_n) && mem_oe_n && mem_we_n && !mem_dq_oe, "R11", "released at ready",
          {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe}, 6'b111110);
      @(negedge clk);
      chk(!req_ready && (&mem_cs_n), "R11", "gap cycle", {req_ready, mem_cs_n}, 4'b0111);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL R11 watchdog actual=timeout expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int c = 0; c < 3; c++) for (int f = 0; f < 4; f++) ws[c][f] = 31;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      ctx = "R1 reset";
      chk((&mem_cs_n) && mem_oe_n && mem_we_n && !mem_dq_oe && !req_ready, "R1", "idle outputs",
          {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready}, 7'b1111100);
      access(0, 0, 24'h000123, 16'h0, 0, 0);   // R1: default count 31
      access(1, 2, 24'hABCDEF, 16'h5A5A, 0, 0);

      ctx = "R9 zero";
      cfg(0, 0, 0);
      access(0, 0, 24'h00F00F, 16'h0, 0, 0);
      cfg(1, 1, 0); cfg(1, 2, 0); cfg(1, 3, 0);
      access(1, 1, 24'h800001, 16'hC0DE, 0, 0);

      ctx = "read sweep";
      for (int c = 0; c < 3; c++)
         for (int v = 1; v <= 7; v += 3) begin
            cfg(c, 0, v + c);
            access(0, c, 24'(24'h010203 * (v + 1) + c), 16'h0, 0, 0);
         end

      ctx = "R10 independence";
      cfg(1, 0, 20);
      access(0, 0, 24'h000444, 16'h0, 0, 0);
      access(0, 1, 24'h000555, 16'h0, 0, 0);

      ctx = "write sweep";
      for (int c = 0; c < 3; c++)
         for (int s = 0; s <= 3; s += 3)
            for (int p = 1; p <= 4; p += 3)
               for (int h = 0; h <= 2; h += 2) begin
                  cfg(c, 1, s); cfg(c, 2, p); cfg(c, 3, h);
                  access(1, c, 24'(24'h102030 + (s << 8) + (p << 4) + h),
                         16'(16'h1111 * (c + 1) + s + p + h), 0, 0);
               end

      ctx = "R3 unmapped";
      access(0, 3, 24'h123456, 16'h0, 0, 0);
      access(1, 3, 24'h654321, 16'hFFFF, 0, 0);

      ctx = "R13 collision";
      cfg(1, 1, 2); cfg(1, 2, 3); cfg(1, 3, 1);
      access(1, 1, 24'h0000AA, 16'hBEEF, 1, 9);   // strobe keeps 3
      access(1, 1, 24'h0000BB, 16'hF00D, 0, 0);   // strobe now 9

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule